// File: doc/BRIEF.md
# Board-Logic Watchdog Timer

This block is a hardware watchdog meant for a board's programmable logic device. Software arms it through a small byte-wide register bus, then keeps it alive by writing a kick register. If the kicks stop, the countdown reaches its end and the block carries out one expiry action. The action is one of three: a reset request pulse, a forced full-speed fan request, or a bump of a saturating event counter. A free-running prescaler divides the system clock into the counting unit. The unit is milliseconds in the exponent format and seconds in the two linear formats.

The timeout format is fixed per instance by `MODE`. Mode 1 rounds any request up to a power of two in milliseconds, capped at 32768 ms, and hides the remaining time. Mode 2 takes an 8-bit count of seconds. Mode 3 takes a 16-bit count of seconds. A status field reports the mode in effect. A board can place a primary instance (`IS_AUX = 0`), which can only reset, next to an auxiliary one (`IS_AUX = 1`) that can use any action. Both can run at the same time. A cause flag records that the watchdog requested a reset. That flag is cleared only by power-on reset, so it is still set after the system reset that the watchdog itself caused.

Top module: `pld_watchdog`

Register map, 8-bit data, 3-bit address:

| Addr | Name | Contents |
|---|---|---|
| 0 | CTRL | bit0 run, bit1 lock, bits[3:2] action |
| 1 | TMO_LO | timeout bits [7:0] |
| 2 | TMO_HI | timeout bits [15:8] |
| 3 | KICK | any write restarts the countdown |
| 4 | LEFT_LO | remaining units [7:0] |
| 5 | LEFT_HI | remaining units [15:8] |
| 6 | STAT | bit0 cause flag (write 1 to clear), bits[2:1] mode code |
| 7 | EVCNT | event counter, zero-extended |

## Requirements
- R1: In mode 1, TMO_LO/TMO_HI read back the written millisecond request rounded up to the next power of two. The result is capped at 32768 (0x8000), a request of 0 reads as 1, and after reset the value is 0x8000. LEFT_LO and LEFT_HI always read 0.
- R2: In mode 2, the timeout is TMO_LO in whole seconds (1 to 255). Writes to TMO_HI are ignored, and TMO_HI and LEFT_HI read 0.
- R3: In mode 3, the timeout is a 16-bit count of seconds stored little-endian: TMO_LO holds bits [7:0] and TMO_HI holds bits [15:8].
- R4: STAT bits [2:1] read the mode code (1, 2 or 3). STAT bit0 reads the cause flag.
- R5: While running, expiry happens exactly T × unit-period clock cycles after the last restart. A restart is a KICK write, a 0→1 change of CTRL run, or a timeout write while running. Kicks spaced less than the timeout apart prevent expiry.
- R6: In modes 2 and 3, LEFT reads the timeout while stopped. After a restart it reads T minus the number of whole units elapsed.
- R7: The reset action (action code 0, and the unused code 3) drives `rst_req` high for exactly `RST_PULSE_CYC` cycles, beginning at expiry.
- R8: The fan action (code 1) sets `fan_full` at expiry without raising `rst_req`. A KICK write, or stopping the watchdog, clears it.
- R9: The count action (code 2) increments `ev_count` at each expiry without raising `rst_req`. The counter saturates at its all-ones value.
- R10: A primary instance ignores the action field. CTRL bits[3:2] read 0, and every expiry is a reset.
- R11: Writing CTRL with both run and lock set locks the instance. Until the next system reset, later writes cannot clear run or lock.
- R12: A reset expiry sets the cause flag. The flag survives `rst_n`, is cleared by writing 1 to STAT bit0, and is cleared by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` Hz |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears all but the cause flag |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Reset request pulse |
| fan_full | output | 1 | Full-speed fan request |
| ev_count | output | EVCNT_W | Saturating expiry counter |

## Verification
The hardest state to reach is the cause flag after a real watchdog reset. To reach it, the bench has to let a primary instance expire, watch the exact reset pulse, and then pull `rst_n` itself as the board would. After that it checks that the control state is gone while the flag remains, and only then clears the flag over the bus. Counter saturation is reached by retuning a running auxiliary instance to a one-second timeout. That retune is itself a restart, so the bench can predict the cycle of every later expiry. Expiry cycles are checked one cycle before and exactly at the predicted edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ACT_RESET = 2'd0,
    ACT_FAN   = 2'd1,
    ACT_COUNT = 2'd2,
    ACT_RSVD  = 2'd3
  } wdt_action_e;

  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_TMO_LO  = 3'd1;
  localparam logic [2:0] A_TMO_HI  = 3'd2;
  localparam logic [2:0] A_KICK    = 3'd3;
  localparam logic [2:0] A_LEFT_LO = 3'd4;
  localparam logic [2:0] A_LEFT_HI = 3'd5;
  localparam logic [2:0] A_STAT    = 3'd6;
  localparam logic [2:0] A_EVCNT   = 3'd7;

  // Smallest power of two not below req, limited to 2^15.
  function automatic logic [15:0] pow2_ceil(input logic [15:0] req);
    logic [4:0] top;
    top = 5'd0;
    for (int i = 0; i < 16; i++) begin
      if (req[i]) top = 5'(i);
    end
    if (req == 16'd0)              return 16'd1;
    else if ($countones(req) == 1) return req;
    else if (top >= 5'd15)         return 16'h8000;
    else                           return 16'd1 << (top + 5'd1);
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr || !run)          pcnt_d = '0;
    else if (pcnt_q == LAST)  pcnt_d = '0;
    else                      pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick = run && !clr && (pcnt_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R5: unit ticks are spaced, never back to back
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] left,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  assign expire = run && !load && tick && (cnt_q <= W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load || !run)  cnt_d = reload_val;
    else if (tick)     cnt_d = (cnt_q <= W'(1)) ? reload_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign left = cnt_q;

  // R5: an expiry restarts the countdown from the programmed value
  p_reload_after_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && $stable(reload_val)) |=> (left == $past(reload_val)));

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
#(
  parameter int PULSE_CYC = 16,
  parameter int EV_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  wdt_action_e     act,
  input  logic            kick,
  input  logic            run,
  output logic            rst_req,
  output logic            fan_full,
  output logic [EV_W-1:0] ev_count
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC - 1);

  logic            is_fan, is_cnt, is_rst;
  logic            pulse_q, pulse_d, fan_q, fan_d;
  logic [PW-1:0]   plen_q, plen_d;
  logic [EV_W-1:0] ev_q, ev_d;

  assign is_fan = (act == ACT_FAN);
  assign is_cnt = (act == ACT_COUNT);
  assign is_rst = !is_fan && !is_cnt;

  always_comb begin
    pulse_d = pulse_q;
    plen_d  = plen_q;
    if (expire && is_rst) begin
      pulse_d = 1'b1;
      plen_d  = PLOAD;
    end else if (pulse_q) begin
      if (plen_q == '0) pulse_d = 1'b0;
      else              plen_d  = plen_q - 1'b1;
    end

    fan_d = fan_q;
    if (expire && is_fan)  fan_d = 1'b1;
    else if (kick || !run) fan_d = 1'b0;

    ev_d = ev_q;
    if (expire && is_cnt && (ev_q != '1)) ev_d = ev_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      plen_q  <= '0;
      fan_q   <= 1'b0;
      ev_q    <= '0;
    end else begin
      pulse_q <= pulse_d;
      plen_q  <= plen_d;
      fan_q   <= fan_d;
      ev_q    <= ev_d;
    end
  end

  assign rst_req  = pulse_q;
  assign fan_full = fan_q;
  assign ev_count = ev_q;

  // R8: a fan expiry never starts a reset pulse
  p_fan_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && is_fan && !pulse_q) |=> !pulse_q);
  // R9: the event counter never goes backwards
  p_evcnt_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q >= $past(ev_q));

endmodule

// File: rtl/pld_watchdog.sv
module pld_watchdog
  import wdt_pkg::*;
#(
  parameter int CLK_HZ        = 1000000,
  parameter int MODE          = 2,
  parameter int IS_AUX        = 1,
  parameter int RST_PULSE_CYC = 16,
  parameter int EVCNT_W       = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               rst_req,
  output logic               fan_full,
  output logic [EVCNT_W-1:0] ev_count
);
  localparam int RAW_DIV  = (MODE == 1) ? CLK_HZ / 1000 : CLK_HZ;
  localparam int UNIT_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam logic [1:0] MODE_CODE = 2'(MODE);

  // Reset: asserted asynchronously, released through two flops.
  logic       sys_arst_n, srst_n;
  logic [1:0] rs_q;
  assign sys_arst_n = por_n & rst_n;

  always_ff @(posedge clk or negedge sys_arst_n) begin
    if (!sys_arst_n) rs_q <= 2'b00;
    else             rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic        en_q, en_d, lock_q, lock_d, cause_q, cause_d;
  wdt_action_e act_q, act_d;
  logic [15:0] raw_q, raw_d, eff_q, eff_d, left;
  logic        wr_ctrl, wr_lo, wr_hi, kick, reload, tick, expire;

  function automatic logic [15:0] effective(input logic [15:0] raw);
    if (MODE == 1)      return pow2_ceil(raw);
    else if (MODE == 2) return {8'h00, raw[7:0]};
    else                return raw;
  endfunction

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_lo   = bus_wr && (bus_addr == A_TMO_LO);
  assign wr_hi   = bus_wr && (bus_addr == A_TMO_HI) && (MODE != 2);
  assign kick    = bus_wr && (bus_addr == A_KICK);

  always_comb begin
    en_d   = en_q;
    lock_d = lock_q;
    act_d  = act_q;
    raw_d  = raw_q;
    if (wr_ctrl) begin
      en_d   = lock_q | bus_wdata[0];
      lock_d = lock_q | (bus_wdata[0] & bus_wdata[1]);
      if (IS_AUX != 0) act_d = wdt_action_e'(bus_wdata[3:2]);
    end
    if (wr_lo) raw_d[7:0]  = bus_wdata;
    if (wr_hi) raw_d[15:8] = bus_wdata;
  end

  assign eff_q  = effective(raw_q);
  assign eff_d  = effective(raw_d);
  assign reload = kick || (en_d && !en_q) || (en_q && (wr_lo || wr_hi));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      act_q  <= ACT_RESET;
      raw_q  <= 16'hFFFF;
    end else begin
      en_q   <= en_d;
      lock_q <= lock_d;
      act_q  <= act_d;
      raw_q  <= raw_d;
    end
  end

  wdt_prescaler #(.DIV(UNIT_DIV)) u_presc (
    .clk(clk), .rst_n(srst_n), .clr(reload), .run(en_q), .tick(tick)
  );

  wdt_countdown #(.W(16)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run(en_q), .load(reload), .tick(tick),
    .reload_val(eff_d), .left(left), .expire(expire)
  );

  wdt_action #(.PULSE_CYC(RST_PULSE_CYC), .EV_W(EVCNT_W)) u_act (
    .clk(clk), .rst_n(srst_n), .expire(expire), .act(act_q), .kick(kick),
    .run(en_q), .rst_req(rst_req), .fan_full(fan_full), .ev_count(ev_count)
  );

  // Cause flag lives on the power-on domain only.
  always_comb begin
    cause_d = cause_q;
    if (bus_wr && (bus_addr == A_STAT) && bus_wdata[0]) cause_d = 1'b0;
    if (expire && (act_q != ACT_FAN) && (act_q != ACT_COUNT)) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= 1'b0;
    else        cause_q <= cause_d;
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_CTRL:    bus_rdata = {4'b0000, act_q, lock_q, en_q};
      A_TMO_LO:  bus_rdata = eff_q[7:0];
      A_TMO_HI:  bus_rdata = eff_q[15:8];
      A_LEFT_LO: bus_rdata = (MODE == 1) ? 8'h00 : left[7:0];
      A_LEFT_HI: bus_rdata = (MODE == 1) ? 8'h00 : left[15:8];
      A_STAT:    bus_rdata = {5'b00000, MODE_CODE, cause_q};
      A_EVCNT:   bus_rdata = 8'(ev_count);
      default:   bus_rdata = 8'h00;
    endcase
  end

  // R11: once locked, the run bit stays set until system reset
  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    $past(lock_q) |-> en_q);
  // R12: every reset pulse start is recorded in the cause flag
  p_cause_on_reset_r12: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rst_req) |-> cause_q);

  generate
    if (IS_AUX == 0) begin : g_main
      // R10: a primary instance never takes a non-reset action
      p_main_reset_only_r10: assert property (@(posedge clk) disable iff (!srst_n)
        !fan_full && $stable(ev_count));
    end
  endgenerate

endmodule

// File: tb/pld_watchdog_bench.sv
module pld_watchdog_bench;
  localparam int HZ = 4000;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic       wr_m, wr_a, wr_2;
  logic [7:0] rd_m, rd_a, rd_2;
  logic       rst_m, rst_a, rst_2, fan_m, fan_a, fan_2;
  logic [7:0] ev_m, ev_2;
  logic [1:0] ev_a;

  always #4 clk = ~clk;

  pld_watchdog #(.CLK_HZ(HZ), .MODE(1), .IS_AUX(0), .RST_PULSE_CYC(8), .EVCNT_W(8)) u_pld_watchdog (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_m),
    .bus_wdata(wdata), .bus_rdata(rd_m), .rst_req(rst_m), .fan_full(fan_m), .ev_count(ev_m));

  pld_watchdog #(.CLK_HZ(HZ), .MODE(3), .IS_AUX(1), .RST_PULSE_CYC(8), .EVCNT_W(2)) u_pld_watchdog_aux (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_a),
    .bus_wdata(wdata), .bus_rdata(rd_a), .rst_req(rst_a), .fan_full(fan_a), .ev_count(ev_a));

  pld_watchdog #(.CLK_HZ(HZ), .MODE(2), .IS_AUX(1), .RST_PULSE_CYC(8), .EVCNT_W(8)) u_pld_watchdog_m2 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_2),
    .bus_wdata(wdata), .bus_rdata(rd_2), .rst_req(rst_2), .fan_full(fan_2), .ev_count(ev_2));

  typedef struct {
    string       req;
    int unsigned act;
    int unsigned exp;
  } item_t;

  item_t q[$];
  event  pushed;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  bit    aux_rst_seen = 0, main_rst_seen = 0;

  always @(negedge clk) begin
    if (rst_a || rst_2) aux_rst_seen = 1'b1;
    if (rst_m)          main_rst_seen = 1'b1;
  end

  // Scoreboard monitor
  task automatic drain();
    while (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (it.act != it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, it.act, it.exp);
      end
    end
  endtask

  initial forever begin
    @(pushed);
    drain();
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    q.push_back(it);
    -> pushed;
    #0;
  endtask

  task automatic wr(input int sel, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr_m = (sel == 0); wr_a = (sel == 1); wr_2 = (sel == 2);
    @(negedge clk);
    wr_m = 1'b0; wr_a = 1'b0; wr_2 = 1'b0;
  endtask

  task automatic rd(input int sel, input logic [2:0] a, output int unsigned v);
    addr = a;
    #1;
    v = (sel == 0) ? rd_m : (sel == 1) ? rd_a : rd_2;
  endtask

  task automatic chk_rd(input string req, input int sel, input logic [2:0] a, input int unsigned exp);
    int unsigned v;
    rd(sel, a, v);
    check(req, v, exp);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      drain();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 1'b0; rst_n = 1'b0; addr = 3'd0; wdata = 8'd0;
    wr_m = 1'b0; wr_a = 1'b0; wr_2 = 1'b0;
    wait_cyc(5);
    por_n = 1'b1; rst_n = 1'b1;
    wait_cyc(4);

    // Reset state, mode code (R4)
    chk_rd("R4 main STAT", 0, 3'd6, 8'h02);
    chk_rd("R4 aux STAT",  1, 3'd6, 8'h06);
    chk_rd("R4 m2 STAT",   2, 3'd6, 8'h04);
    chk_rd("R11 reset CTRL", 0, 3'd0, 8'h00);
    chk_rd("R1 reset TMO_HI", 0, 3'd2, 8'h80);

    // R1 rounding
    wr(0, 3'd1, 8'h20); wr(0, 3'd2, 8'h4E);
    chk_rd("R1 20000 lo", 0, 3'd1, 8'h00);
    chk_rd("R1 20000 hi", 0, 3'd2, 8'h80);
    wr(0, 3'd1, 8'h00); wr(0, 3'd2, 8'h04);
    chk_rd("R1 1024 hi", 0, 3'd2, 8'h04);
    wr(0, 3'd1, 8'h01); wr(0, 3'd2, 8'h80);
    chk_rd("R1 cap hi", 0, 3'd2, 8'h80);
    chk_rd("R1 cap lo", 0, 3'd1, 8'h00);
    wr(0, 3'd1, 8'h00); wr(0, 3'd2, 8'h00);
    chk_rd("R1 zero lo", 0, 3'd1, 8'h01);
    wr(0, 3'd1, 8'd20);
    chk_rd("R1 20 lo", 0, 3'd1, 8'h20);
    chk_rd("R1 20 hi", 0, 3'd2, 8'h00);

    // R10 + R5 + R7: enable with fan code on primary; expires at 32*4 cycles
    wr(0, 3'd0, 8'h05);
    chk_rd("R10 main CTRL action", 0, 3'd0, 8'h01);
    chk_rd("R1 LEFT_LO zero", 0, 3'd4, 8'h00);
    wait_cyc(127);
    check("R5 main not yet", rst_m, 0);
    wait_cyc(1);
    check("R5 main expiry edge", rst_m, 1);
    n = 0;
    while (rst_m && n < 50) begin n++; wait_cyc(1); end
    check("R7 pulse length", n, 8);
    check("R10 main no fan", fan_m, 0);
    chk_rd("R12 cause set", 0, 3'd6, 8'h03);
    sys_reset();
    chk_rd("R12 CTRL cleared", 0, 3'd0, 8'h00);
    chk_rd("R12 cause survives", 0, 3'd6, 8'h03);
    wr(0, 3'd6, 8'h01);
    chk_rd("R12 cause W1C", 0, 3'd6, 8'h02);

    // R5 kicks hold off expiry
    wr(0, 3'd2, 8'h00); wr(0, 3'd1, 8'd20);
    main_rst_seen = 1'b0;
    wr(0, 3'd0, 8'h01);
    wait_cyc(100); wr(0, 3'd3, 8'h00);
    wait_cyc(100); wr(0, 3'd3, 8'h00);
    wait_cyc(100);
    check("R5 kicks prevent expiry", main_rst_seen, 0);
    wr(0, 3'd3, 8'h00);
    wait_cyc(127);
    check("R5 after kick not yet", rst_m, 0);
    wait_cyc(1);
    check("R5 after kick expiry", rst_m, 1);
    wait_cyc(10);
    sys_reset();

    // R11 lock
    wr(0, 3'd2, 8'h04); wr(0, 3'd1, 8'h00);
    wr(0, 3'd0, 8'h03);
    wr(0, 3'd0, 8'h00);
    chk_rd("R11 locked CTRL", 0, 3'd0, 8'h03);
    sys_reset();
    chk_rd("R11 unlocked by reset", 0, 3'd0, 8'h00);
    wr(0, 3'd6, 8'h01);

    // R3 little-endian 16-bit seconds, R6 left while stopped
    wr(1, 3'd1, 8'h34); wr(1, 3'd2, 8'h12);
    chk_rd("R3 TMO_LO", 1, 3'd1, 8'h34);
    chk_rd("R3 TMO_HI", 1, 3'd2, 8'h12);
    chk_rd("R6 LEFT_LO stopped", 1, 3'd4, 8'h34);
    chk_rd("R6 LEFT_HI stopped", 1, 3'd5, 8'h12);

    // R9 count action, R6 time left
    wr(1, 3'd2, 8'h00); wr(1, 3'd1, 8'd3);
    wr(1, 3'd0, 8'h09);
    chk_rd("R10 aux keeps action", 1, 3'd0, 8'h09);
    wait_cyc(6000);
    chk_rd("R6 aux left 2", 1, 3'd4, 8'd2);
    chk_rd("R6 aux left hi", 1, 3'd5, 8'd0);
    wait_cyc(5999);
    check("R9 count before", ev_a, 0);
    wait_cyc(1);
    check("R9 count after", ev_a, 1);
    wr(1, 3'd1, 8'd1);
    wait_cyc(3999);
    check("R5 retune restart not yet", ev_a, 1);
    wait_cyc(1);
    check("R9 second count", ev_a, 2);
    wait_cyc(8001);
    check("R9 saturate", ev_a, 3);
    chk_rd("R9 EVCNT reg", 1, 3'd7, 8'd3);

    // R8 fan action
    wr(1, 3'd0, 8'h05);
    wr(1, 3'd3, 8'h00);
    wait_cyc(3999);
    check("R8 fan not yet", fan_a, 0);
    wait_cyc(1);
    check("R8 fan set", fan_a, 1);
    wait_cyc(10);
    check("R8 fan held", fan_a, 1);
    wr(1, 3'd3, 8'h00);
    check("R8 fan cleared by kick", fan_a, 0);

    // R2 8-bit seconds
    wr(2, 3'd1, 8'hC8); wr(2, 3'd2, 8'h55);
    chk_rd("R2 TMO_LO", 2, 3'd1, 8'hC8);
    chk_rd("R2 TMO_HI ignored", 2, 3'd2, 8'h00);
    wr(2, 3'd1, 8'hFF);
    chk_rd("R2 max 255", 2, 3'd1, 8'hFF);
    wr(2, 3'd1, 8'd2);
    wr(2, 3'd0, 8'h09);
    wait_cyc(5000);
    chk_rd("R6 m2 left 1", 2, 3'd4, 8'd1);
    chk_rd("R2 LEFT_HI zero", 2, 3'd5, 8'd0);
    wait_cyc(2999);
    check("R9 m2 before", ev_2, 0);
    wait_cyc(1);
    check("R9 m2 after", ev_2, 1);
    check("R8 R9 aux never reset", aux_rst_seen, 0);

    #1;
    drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule